// File: doc/BRIEF.md
# Modem Line Status Tracker

This block keeps the status byte that a serial port controller shows for its four incoming modem handshake lines: clear-to-send, data-set-ready, ring and carrier detect. Each line passes through a synchroniser. Its settled level is then stored in the upper nibble of the byte. A matching flag in the lower nibble latches each change, so software sees a transition even after the line has moved back.

The host reads the byte through a strobe. The byte is driven combinationally while the strobe is high. On the clock edge that ends the read, the change flags are cleared. A single flag output carries the OR of the pending change flags to the interrupt logic.

In self-test loopback the read returns the four modem control outputs in place of the external lines, with the change flags shown as zero. The stored flags are kept through loopback.

Top module: `modem_status_unit`

## Requirements
- R1: Outside loopback, rd_data holds the settled lines in bits 7..4 (7 carrier detect, 6 ring, 5 data-set-ready, 4 clear-to-send) and the change flags in bits 3..0 (3 carrier change, 2 ring trailing edge, 1 data-set-ready change, 0 clear-to-send change).
- R2: Any change, in either direction, of the settled carrier, data-set-ready or clear-to-send level sets that line's change flag. The flag stays set until it is cleared.
- R3: The ring flag (bit 2) is set only when the settled ring level falls from 1 to 0. A rise from 0 to 1 leaves it unchanged.
- R4: A read (rd_stb high with loop_en low) clears bits 3..0 at the clock edge that ends the read. Bits 7..4 are not affected.
- R5: With loop_en high, rd_data is {ctl_out2, ctl_out1, ctl_dtr, ctl_rts, 4'b0000}. A read in this mode leaves the stored change flags unchanged.
- R6: After reset, rd_data reads 8'hB0 and delta_any is 0, provided the lines are held at carrier=1, ring=0, data-set-ready=1, clear-to-send=1.
- R7: delta_any is the OR of the stored change flags, in loopback as well.
- R8: If a flag-setting change is registered at the same edge as a clearing read, that flag is set afterwards, and all other flags are cleared.
- R9: A line change reaches rd_data SYNC_STAGES+1 clock edges after it is applied, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mdm_cts_i | input | 1 | Clear-to-send line, asynchronous |
| mdm_dsr_i | input | 1 | Data-set-ready line, asynchronous |
| mdm_ri_i | input | 1 | Ring line, asynchronous |
| mdm_dcd_i | input | 1 | Carrier detect line, asynchronous |
| loop_en | input | 1 | Loopback mode select |
| ctl_dtr | input | 1 | Terminal-ready control output, looped back as data-set-ready |
| ctl_rts | input | 1 | Request-to-send control output, looped back as clear-to-send |
| ctl_out1 | input | 1 | User output 1, looped back as ring |
| ctl_out2 | input | 1 | User output 2, looped back as carrier detect |
| rd_stb | input | 1 | Host read strobe |
| rd_data | output | 8 | Status byte |
| delta_any | output | 1 | OR of the pending change flags |

## Verification
A line transition and a clearing read can be registered at the same clock edge. The bench provokes this by changing clear-to-send and counting exactly SYNC_STAGES edges. It then holds the read strobe across the next edge, so the clear and the new flag meet at that edge. The byte returned by that read must not yet show the change. The next read must show only the new clear-to-send flag, with the earlier data-set-ready flag gone.

// File: rtl/msd_pkg.sv
package msd_pkg;
   localparam int NLINES = 4;
   localparam int LN_CTS = 0;
   localparam int LN_DSR = 1;
   localparam int LN_RI  = 2;
   localparam int LN_DCD = 3;
   localparam int CTL_DTR  = 0;
   localparam int CTL_RTS  = 1;
   localparam int CTL_OUT1 = 2;
   localparam int CTL_OUT2 = 3;
   localparam logic [NLINES-1:0] LINES_IDLE = 4'b1011;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
   parameter int              STAGES  = 2,
   parameter int              WIDTH   = 4,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("msd_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_bypass
         assign sync_o = async_i;
      end else begin : g_chain
         logic [WIDTH-1:0] stg_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
            end else begin
               stg_q[0] <= async_i;
               for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
            end
         end
         assign sync_o = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/msd_delta.sv
module msd_delta #(
   parameter int               WIDTH    = 4,
   parameter int               RING_IDX = 2,
   parameter logic [WIDTH-1:0] RST_VAL  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] samp_i,
   input  logic             clr_i,
   output logic [WIDTH-1:0] level_o,
   output logic [WIDTH-1:0] delta_o
);
   logic [WIDTH-1:0] level_q, delta_q, set_w;

   generate
      if (RING_IDX < 0 || RING_IDX >= WIDTH) begin : g_bad
         $error("msd_delta: RING_IDX out of range");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i == RING_IDX) begin : g_trail
            assign set_w[i] = level_q[i] & ~samp_i[i];
         end else begin : g_any
            assign set_w[i] = level_q[i] ^ samp_i[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= RST_VAL;
         delta_q <= '0;
      end else begin
         level_q <= samp_i;
         delta_q <= (clr_i ? '0 : delta_q) | set_w;
      end
   end

   assign level_o = level_q;
   assign delta_o = delta_q;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_chk
         if (i == RING_IDX) begin : g_ring
            assert_ring_rise_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
               (!level_q[i] && samp_i[i]) |=> (delta_q[i] == ($past(delta_q[i]) && !$past(clr_i))));
            assert_ring_fall_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
               (level_q[i] && !samp_i[i]) |=> delta_q[i]);
         end else begin : g_line
            assert_change_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
               (level_q[i] != samp_i[i]) |=> delta_q[i]);
         end
      end
   endgenerate

   assert_quiet_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && (level_q == samp_i)) |=> (delta_q == '0));
   assert_level_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (level_q == $past(samp_i)));
endmodule

// File: rtl/msd_view.sv
module msd_view
   import msd_pkg::*;
(
   input  logic              loop_en,
   input  logic [NLINES-1:0] ctl_i,
   input  logic [NLINES-1:0] level_i,
   input  logic [NLINES-1:0] delta_i,
   output logic [2*NLINES-1:0] byte_o
);
   logic [NLINES-1:0] loop_lines;

   always_comb begin
      loop_lines         = '0;
      loop_lines[LN_DCD] = ctl_i[CTL_OUT2];
      loop_lines[LN_RI]  = ctl_i[CTL_OUT1];
      loop_lines[LN_DSR] = ctl_i[CTL_DTR];
      loop_lines[LN_CTS] = ctl_i[CTL_RTS];
   end

   assign byte_o = loop_en ? {loop_lines, {NLINES{1'b0}}} : {level_i, delta_i};
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
   import msd_pkg::*;
#(
   parameter int                SYNC_STAGES = 2,
   parameter logic [NLINES-1:0] RST_LINES   = LINES_IDLE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mdm_cts_i,
   input  logic       mdm_dsr_i,
   input  logic       mdm_ri_i,
   input  logic       mdm_dcd_i,
   input  logic       loop_en,
   input  logic       ctl_dtr,
   input  logic       ctl_rts,
   input  logic       ctl_out1,
   input  logic       ctl_out2,
   input  logic       rd_stb,
   output logic [7:0] rd_data,
   output logic       delta_any
);
   localparam int BYTE_W = 2 * NLINES;

   logic [NLINES-1:0] raw_w, samp_w, level_w, delta_w, ctl_w;
   logic              clr_w;

   assign raw_w = {mdm_dcd_i, mdm_ri_i, mdm_dsr_i, mdm_cts_i};
   assign ctl_w = {ctl_out2, ctl_out1, ctl_rts, ctl_dtr};
   assign clr_w = rd_stb & ~loop_en;

   msd_sync #(.STAGES(SYNC_STAGES), .WIDTH(NLINES), .RST_VAL(RST_LINES)) i_sync (
      .clk(clk), .rst_n(rst_n), .async_i(raw_w), .sync_o(samp_w));

   msd_delta #(.WIDTH(NLINES), .RING_IDX(LN_RI), .RST_VAL(RST_LINES)) i_delta (
      .clk(clk), .rst_n(rst_n), .samp_i(samp_w), .clr_i(clr_w),
      .level_o(level_w), .delta_o(delta_w));

   logic [BYTE_W-1:0] byte_w;
   msd_view i_view (
      .loop_en(loop_en), .ctl_i(ctl_w), .level_i(level_w),
      .delta_i(delta_w), .byte_o(byte_w));

   assign rd_data   = byte_w;
   assign delta_any = |delta_w;

   assert_loop_no_delta_R5: assert property (@(posedge clk) disable iff (!rst_n)
      loop_en |-> (rd_data[3:0] == 4'b0000));
   assert_loop_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && loop_en) |=> (delta_any || !$past(delta_any) || (samp_w != level_w)) || delta_any == $past(delta_any));
   assert_any_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en |-> (delta_any == (rd_data[3:0] != 4'b0000)));
   assert_upper_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !loop_en |-> (rd_data[7:4] == level_w));
endmodule

// File: tb/test_modem_status_unit.sv
module test_modem_status_unit;
   localparam int CLK_PERIOD = 10;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cts = 1'b1, dsr = 1'b1, ri = 1'b0, dcd = 1'b1;
   logic loop_en = 1'b0, dtr = 1'b0, rts = 1'b0, out1 = 1'b0, out2 = 1'b0;
   logic rd_stb = 1'b0;
   logic [7:0] rd_data;
   logic delta_any;
   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   modem_status_unit #(.SYNC_STAGES(SYNC)) i_modem_status_unit (
      .clk(clk), .rst_n(rst_n), .mdm_cts_i(cts), .mdm_dsr_i(dsr),
      .mdm_ri_i(ri), .mdm_dcd_i(dcd), .loop_en(loop_en), .ctl_dtr(dtr),
      .ctl_rts(rts), .ctl_out1(out1), .ctl_out2(out2), .rd_stb(rd_stb),
      .rd_data(rd_data), .delta_any(delta_any));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // line vector index: 0 cts, 1 dsr, 2 ri, 3 dcd
   task automatic set_lines(input logic [3:0] v);
      {dcd, ri, dsr, cts} = v;
   endtask

   task automatic settle();
      repeat (SYNC + 2) @(negedge clk);
   endtask

   task automatic do_read(output logic [7:0] d);
      rd_stb = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   initial begin
      logic [7:0] d;
      logic [3:0] exp_d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6 reset state
      check("R6 byte", rd_data, 8'hB0);
      check("R6 any", {7'b0, delta_any}, 8'h00);

      // R1 R2 R3 R4 R7 sweep of every old/new line pattern
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            set_lines(a[3:0]); settle(); do_read(d);
            set_lines(b[3:0]); settle();
            exp_d = {a[3] ^ b[3], a[2] & ~b[2], a[1] ^ b[1], a[0] ^ b[0]};
            check("R7 any", {7'b0, delta_any}, {7'b0, |exp_d});
            do_read(d);
            check("R1 R2 R3 byte", d, {b[3:0], exp_d});
            do_read(d);
            check("R4 cleared", d, {b[3:0], 4'b0000});
         end
      end

      // R8 R9 coincident change and clear
      set_lines(4'b1011); settle(); do_read(d);
      set_lines(4'b1001); settle();
      check("R8 setup", rd_data, 8'h92);
      set_lines(4'b1000);
      repeat (SYNC) @(negedge clk);
      check("R9 not yet", rd_data, 8'h92);
      do_read(d);
      check("R8 read value", d, 8'h92);
      check("R8 kept new", rd_data, 8'h81);
      check("R8 any", {7'b0, delta_any}, 8'h01);
      do_read(d);

      // R5 loopback mapping and retention
      set_lines(4'b0000); settle();
      check("R5 setup", rd_data, 8'h08);
      loop_en = 1'b1;
      for (int c = 0; c < 16; c++) begin
         {out2, out1, rts, dtr} = c[3:0];
         #1;
         check("R5 loop byte", rd_data, {c[3], c[2], c[0], c[1], 4'b0000});
         check("R7 loop any", {7'b0, delta_any}, 8'h01);
      end
      do_read(d);
      loop_en = 1'b0;
      #1;
      check("R5 retained", rd_data, 8'h08);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule